// File: doc/BRIEF.md
# MSI Doorbell Receiver Register Bank

This block receives message-signalled interrupts as plain bus writes. An agent writes a vector number to a single index register. The block turns that number into one sticky bit in a bank of 32-bit status words. Vector V lands in word V/32 at bit V%32. With the default 256 vectors, there are eight status words, and each word drives its own level interrupt line.

Software services a line by reading the matching status word. The read returns the pending bits and clears exactly those bits at the same clock edge, so no separate acknowledge write exists. The port has a separate write channel and read channel. Both are single-cycle, so a doorbell write and a clearing read can land in the same cycle.

A parameter selects one of two address layouts:
- **Wide layout:** status words are 16 bytes apart and the index register is at 0x140.
- **Narrow layout:** status words are 4 bytes apart and the index register is at 0x38.

Top module: `msi_doorbell_bank`

## Requirements
- R1: A synchronous active-low reset (`rst_n` low at a rising edge) clears every status bit, and all `irq_o` lines are low from the next cycle.
- R2: A write of value V (0..255) to the index register sets bit V%32 of status word V/32 at the next rising edge. Bits already set stay set until a read clears them.
- R3: `irq_o[g]` is high exactly while status word g holds any set bit. This means it rises in the cycle after the write that sets the first bit.
- R4: A read of status word g returns that word's current contents on `rd_data` in the same cycle, combinationally. At the following edge, exactly the returned bits are cleared.
- R5: If an index write and a read of the same status word fall in one cycle, the read returns the word as it was before the write. The newly written bit remains set afterwards, even if it equals a bit that was just returned.
- R6: An index write whose 32-bit value is 256 or greater is ignored and sets no bit. Upper bits are not masked off; for example, 0x1000_0005 does not set bit 5.
- R7: Repeated writes of the same vector before a read leave a single set bit, which one read clears.
- R8: Reads of any offset other than a status word return zero and clear nothing. This includes the write-only index register and unaligned offsets. Writes to status-word offsets, or to any offset other than the index register, change nothing.
- R9: With `MAP` = wide (0), status word g is at offset g*0x10 and the index register is at 0x140. With `MAP` = narrow (1), status word g is at g*0x4 and the index register is at 0x38.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all state changes on the rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| wr_en | input | 1 | Write strobe for one cycle |
| wr_addr | input | ADDR_W (12) | Byte offset of the write |
| wr_data | input | WORD_W (32) | Write data; for the index register this is the vector number |
| rd_en | input | 1 | Read strobe for one cycle; a status read also clears |
| rd_addr | input | ADDR_W (12) | Byte offset of the read |
| rd_data | output | WORD_W (32) | Read data, valid in the cycle of `rd_en`, zero otherwise |
| irq_o | output | NUM_VEC/WORD_W (8) | One level interrupt per status word |

## Verification
The doorbell capture and the clearing read can meet in one cycle on the same status word. The bench provokes this by driving an index write and a status read together after an earlier vector has already been captured in that word. It runs the case once with a different bit and once with the very bit being returned.

The bench judges the result three ways:
- `rd_data` in that cycle must show only the earlier bit.
- The word's interrupt must stay high afterwards.
- A follow-up read must return exactly the newly written bit.

// File: rtl/msi_bank_pkg.sv
// Package: shared layout selector and layout-dependent constants for the
// doorbell register bank. Assumes byte offsets and 32-bit aligned words.
package msi_bank_pkg;

    typedef enum logic {
        MAP_WIDE   = 1'b0,
        MAP_NARROW = 1'b1
    } map_kind_e;

    // Byte distance between consecutive status words for a layout.
    function automatic int unsigned grp_stride(map_kind_e m);
        return (m == MAP_WIDE) ? 16 : 4;
    endfunction

    // Byte offset of the write-only index (doorbell) register for a layout.
    function automatic int unsigned idx_offset(map_kind_e m);
        return (m == MAP_WIDE) ? 32'h140 : 32'h38;
    endfunction

endpackage

// File: rtl/msi_addr_dec.sv
// Module: address decoder for the doorbell bank.
// Decodes the write offset against the index register and the read offset
// against each status word. Assumes the two channels are independent and
// that only exact offsets hit (unaligned offsets decode to nothing).
module msi_addr_dec
    import msi_bank_pkg::*;
#(
    parameter int unsigned ADDR_W  = 12,
    parameter int unsigned NUM_GRP = 8,
    parameter map_kind_e   MAP     = MAP_WIDE
) (
    input  logic [ADDR_W-1:0]  wr_addr,
    input  logic [ADDR_W-1:0]  rd_addr,
    output logic               idx_hit,
    output logic [NUM_GRP-1:0] grp_hit
);

    localparam int unsigned STRIDE  = grp_stride(MAP);
    localparam int unsigned IDX_OFF = idx_offset(MAP);

    // Index register match on the write channel.
    assign idx_hit = (wr_addr == ADDR_W'(IDX_OFF));

    // One status-word match per group on the read channel.
    for (genvar g = 0; g < NUM_GRP; g++) begin : g_grp
        assign grp_hit[g] = (rd_addr == ADDR_W'(g * STRIDE));
    end

endmodule

// File: rtl/msi_vec_dec.sv
// Module: vector decoder.
// Turns the data word of an index write into one set mask per status word.
// Assumes the whole data word is the vector number; values at or above
// NUM_VEC produce no mask at all.
module msi_vec_dec #(
    parameter int unsigned WORD_W  = 32,
    parameter int unsigned NUM_VEC = 256,
    parameter int unsigned NUM_GRP = NUM_VEC / WORD_W
) (
    input  logic                            set_en,
    input  logic [WORD_W-1:0]               vec_in,
    output logic [NUM_GRP-1:0][WORD_W-1:0]  set_mask
);

    localparam int unsigned BIT_W = $clog2(WORD_W);
    localparam int unsigned VEC_W = $clog2(NUM_VEC);
    localparam int unsigned GRP_W = VEC_W - BIT_W;

    logic              in_range;
    logic [GRP_W-1:0]  grp_sel;
    logic [BIT_W-1:0]  bit_sel;
    logic [WORD_W-1:0] bit_onehot;

    // Range check on the full data word, then split into group and bit.
    assign in_range   = set_en && (vec_in < WORD_W'(NUM_VEC));
    assign grp_sel    = vec_in[VEC_W-1:BIT_W];
    assign bit_sel    = vec_in[BIT_W-1:0];
    assign bit_onehot = WORD_W'(1) << bit_sel;

    // Route the one-hot bit to the selected group only.
    for (genvar g = 0; g < NUM_GRP; g++) begin : g_mask
        assign set_mask[g] = (in_range && (grp_sel == GRP_W'(g))) ? bit_onehot : '0;
    end

endmodule

// File: rtl/msi_status_grp.sv
// Module: one sticky status word with read-to-clear and a level interrupt.
// Assumes set_mask is zero or one-hot, and rd_hit is high only for a read
// of this word. Bits returned by a read are cleared at the same edge; bits
// set in that cycle survive.
module msi_status_grp #(
    parameter int unsigned WORD_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [WORD_W-1:0] set_mask,
    input  logic              rd_hit,
    output logic [WORD_W-1:0] rd_val,
    output logic              irq
);

    logic [WORD_W-1:0] status_q;

    // Returned value: the current word while this word is being read.
    assign rd_val = rd_hit ? status_q : '0;

    // Level interrupt while any bit is pending.
    assign irq = |status_q;

    // Sticky capture: clear exactly what was returned, then merge new sets.
    always_ff @(posedge clk) begin
        if (!rst_n) status_q <= '0;
        else        status_q <= (status_q & ~rd_val) | set_mask;
    end

    // R2
    set_capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (|set_mask) |=> ((status_q & $past(set_mask)) == $past(set_mask)));

    // R2
    sticky_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!rd_hit) |=> ((status_q & $past(status_q)) == $past(status_q)));

    // R4
    read_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_hit && (set_mask == '0)) |=> (status_q == '0));

    // R5
    collide_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_hit && (|set_mask)) |=> (status_q == $past(set_mask)));

    // R7
    single_bit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(set_mask));

endmodule

// File: rtl/msi_doorbell_bank.sv
// Module: top of the doorbell receiver register bank.
// Index writes become sticky bits in NUM_VEC/WORD_W status words; each word
// has its own level interrupt; reading a word clears what it returns.
// Assumes single-cycle strobes and a layout chosen at elaboration by MAP.
module msi_doorbell_bank
    import msi_bank_pkg::*;
#(
    parameter int unsigned NUM_VEC = 256,
    parameter int unsigned WORD_W  = 32,
    parameter int unsigned ADDR_W  = 12,
    parameter map_kind_e   MAP     = MAP_WIDE
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        wr_en,
    input  logic [ADDR_W-1:0]           wr_addr,
    input  logic [WORD_W-1:0]           wr_data,
    input  logic                        rd_en,
    input  logic [ADDR_W-1:0]           rd_addr,
    output logic [WORD_W-1:0]           rd_data,
    output logic [NUM_VEC/WORD_W-1:0]   irq_o
);

    localparam int unsigned NUM_GRP = NUM_VEC / WORD_W;

    logic                           idx_hit;
    logic [NUM_GRP-1:0]             grp_hit;
    logic [NUM_GRP-1:0]             rd_hit;
    logic [NUM_GRP-1:0][WORD_W-1:0] set_mask;
    logic [NUM_GRP-1:0][WORD_W-1:0] grp_val;

    // Offset decode for both channels.
    msi_addr_dec #(
        .ADDR_W  (ADDR_W),
        .NUM_GRP (NUM_GRP),
        .MAP     (MAP)
    ) u_addr_dec (
        .wr_addr (wr_addr),
        .rd_addr (rd_addr),
        .idx_hit (idx_hit),
        .grp_hit (grp_hit)
    );

    // Vector number to per-word set masks.
    msi_vec_dec #(
        .WORD_W  (WORD_W),
        .NUM_VEC (NUM_VEC),
        .NUM_GRP (NUM_GRP)
    ) u_vec_dec (
        .set_en   (wr_en && idx_hit),
        .vec_in   (wr_data),
        .set_mask (set_mask)
    );

    // One status word per group.
    for (genvar g = 0; g < NUM_GRP; g++) begin : g_word
        assign rd_hit[g] = rd_en && grp_hit[g];

        msi_status_grp #(
            .WORD_W (WORD_W)
        ) u_word (
            .clk      (clk),
            .rst_n    (rst_n),
            .set_mask (set_mask[g]),
            .rd_hit   (rd_hit[g]),
            .rd_val   (grp_val[g]),
            .irq      (irq_o[g])
        );
    end

    // Read return: OR of the gated word values (at most one is non-zero).
    always_comb begin
        rd_data = '0;
        for (int g = 0; g < NUM_GRP; g++) rd_data |= grp_val[g];
    end

    // R8
    rd_decode_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(grp_hit));

    // R8
    unmapped_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && (grp_hit == '0)) |-> (rd_data == '0));

    // R6
    out_of_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && idx_hit && (wr_data >= WORD_W'(NUM_VEC)) && !rd_en)
        |=> (irq_o == $past(irq_o)));

    // R3
    irq_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_o != '0) && ($past(irq_o) == '0) |-> $past(wr_en && idx_hit));

endmodule

// File: tb/msi_doorbell_bank_bench.sv
`timescale 1ns/1ps
module msi_doorbell_bank_bench;

    localparam int unsigned AW = 12;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [AW-1:0] wr_addr = '0;
    logic [31:0] wr_data = '0;
    logic        rd_en = 1'b0;
    logic [AW-1:0] rd_addr = '0;
    logic [31:0] rd_data_a, rd_data_b;
    logic [7:0]  irq_a, irq_b;

    int n_chk = 0;
    int n_fail = 0;
    logic [31:0] cap_a, cap_b;

    always #4 clk = ~clk;

    msi_doorbell_bank #(.MAP(msi_bank_pkg::MAP_WIDE)) u_msi_doorbell_bank (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .rd_en(rd_en), .rd_addr(rd_addr),
        .rd_data(rd_data_a), .irq_o(irq_a));

    msi_doorbell_bank #(.MAP(msi_bank_pkg::MAP_NARROW)) u_msi_doorbell_bank_nar (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .rd_en(rd_en), .rd_addr(rd_addr),
        .rd_data(rd_data_b), .irq_o(irq_b));

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // One bus cycle; read data captured before the edge that applies it.
    task automatic cyc(input logic w, input logic [AW-1:0] wa, input logic [31:0] wd,
                       input logic r, input logic [AW-1:0] ra);
        @(negedge clk);
        wr_en = w; wr_addr = wa; wr_data = wd;
        rd_en = r; rd_addr = ra;
        #1;
        cap_a = rd_data_a; cap_b = rd_data_b;
        @(posedge clk);
        #1;
        wr_en = 0; rd_en = 0; wr_addr = '0; rd_addr = '0; wr_data = '0;
    endtask

    task automatic ring(input logic [31:0] v);
        cyc(1'b1, 12'h140, v, 1'b0, '0);
    endtask

    task automatic rd_word(input int g);
        cyc(1'b0, '0, '0, 1'b1, AW'(g * 16));
    endtask

    task automatic irq_is(input string req, input logic [7:0] exp);
        @(negedge clk);
        chk(req, {24'h0, irq_a}, {24'h0, exp});
    endtask

    task automatic t_reset_state;
        irq_is("R1 irq after reset", 8'h00);
        chk("R1 narrow irq after reset", {24'h0, irq_b}, 32'h0);
        for (int g = 0; g < 8; g++) begin
            rd_word(g);
            chk("R1 word zero after reset", cap_a, 32'h0);
        end
    endtask

    task automatic t_single_vectors;
        int vs[8] = '{0, 31, 32, 63, 100, 130, 223, 255};
        foreach (vs[i]) begin
            ring(vs[i]);
            irq_is("R3 irq rises for vector group", 8'(1 << (vs[i] / 32)));
            rd_word(vs[i] / 32);
            chk("R2/R4 read returns vector bit", cap_a, 32'(1) << (vs[i] % 32));
            irq_is("R4 irq falls after clearing read", 8'h00);
        end
    endtask

    task automatic t_all_groups;
        for (int g = 0; g < 8; g++) ring(g * 32 + g);
        irq_is("R3 every group interrupt", 8'hFF);
        for (int g = 0; g < 8; g++) begin
            rd_word(g);
            chk("R2 per-group bit", cap_a, 32'(1) << g);
        end
        irq_is("R4 all cleared", 8'h00);
    endtask

    task automatic t_accumulate;
        ring(64); ring(65); ring(95);
        rd_word(2);
        chk("R2 bits accumulate in word", cap_a, 32'h8000_0003);
    endtask

    task automatic t_repeat;
        ring(77); ring(77); ring(77);
        rd_word(2);
        chk("R7 repeated vector single bit", cap_a, 32'h0000_2000);
        rd_word(2);
        chk("R7 one read clears repeats", cap_a, 32'h0);
    endtask

    task automatic t_out_of_range;
        ring(256); ring(32'hFFFF_FFFF); ring(32'h1000_0005);
        irq_is("R6 out-of-range ignored", 8'h00);
        rd_word(0);
        chk("R6 upper bits not masked", cap_a, 32'h0);
    endtask

    task automatic t_collide;
        ring(40);
        cyc(1'b1, 12'h140, 32'd45, 1'b1, 12'h010);
        chk("R5 read in collision returns old bits", cap_a, 32'h0000_0100);
        irq_is("R5 irq stays after collision", 8'h02);
        rd_word(1);
        chk("R5 new bit survives", cap_a, 32'h0000_2000);
        ring(40);
        cyc(1'b1, 12'h140, 32'd40, 1'b1, 12'h010);
        chk("R5 same-bit collision read", cap_a, 32'h0000_0100);
        rd_word(1);
        chk("R5 same bit survives", cap_a, 32'h0000_0100);
    endtask

    task automatic t_unmapped;
        ring(3);
        cyc(1'b0, '0, '0, 1'b1, 12'h144);
        chk("R8 read past index", cap_a, 32'h0);
        cyc(1'b0, '0, '0, 1'b1, 12'h140);
        chk("R8 index reads zero", cap_a, 32'h0);
        cyc(1'b0, '0, '0, 1'b1, 12'h004);
        chk("R8 unaligned read", cap_a, 32'h0);
        cyc(1'b0, '0, '0, 1'b1, 12'h080);
        chk("R8 beyond last word", cap_a, 32'h0);
        cyc(1'b1, 12'h000, 32'hFFFF_FFFF, 1'b0, '0);
        cyc(1'b1, 12'h010, 32'hFFFF_FFFF, 1'b0, '0);
        irq_is("R8 status writes ignored", 8'h01);
        rd_word(0);
        chk("R8 word intact after unmapped access", cap_a, 32'h0000_0008);
    endtask

    task automatic t_narrow_map;
        cyc(1'b1, 12'h038, 32'h45, 1'b0, '0);
        @(negedge clk);
        chk("R9 narrow index hit", {24'h0, irq_b}, 32'h04);
        chk("R9 wide ignores narrow index", {24'h0, irq_a}, 32'h0);
        cyc(1'b0, '0, '0, 1'b1, 12'h008);
        chk("R9 narrow word stride", cap_b, 32'h0000_0020);
        chk("R9 wide unmapped at 0x08", cap_a, 32'h0);
        ring(255);
        cyc(1'b0, '0, '0, 1'b1, 12'h01C);
        chk("R9 narrow ignores wide index", cap_b, 32'h0);
        chk("R9 wide irq on top word", {24'h0, irq_a}, 32'h80);
        rd_word(7);
        chk("R9 wide word at 0x70", cap_a, 32'h8000_0000);
    endtask

    task automatic t_reset_mid;
        ring(5); ring(200);
        @(negedge clk); rst_n = 0;
        @(negedge clk); rst_n = 1;
        irq_is("R1 reset clears pending", 8'h00);
        rd_word(6);
        chk("R1 word cleared by reset", cap_a, 32'h0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        t_reset_state();
        t_single_vectors();
        t_all_groups();
        t_accumulate();
        t_repeat();
        t_out_of_range();
        t_collide();
        t_unmapped();
        t_narrow_map();
        t_reset_mid();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        #(8 * 200000);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule